// File: doc/BRIEF.md
# Write-Back Data Cache with Eviction Queue

This block is a very small, fully associative data cache between a processor and a line-oriented memory. The processor side issues single-byte loads and stores through a valid/ready request and gets a one-cycle response pulse carrying the loaded byte and a flag that says whether the access hit. Stores are absorbed by the cache: a store to a resident line changes only the cached copy and marks the line dirty, so memory sees nothing until that line is later displaced.

Memory traffic always moves whole lines. A miss fetches the full line over a request/acknowledge read port. If the line chosen for replacement is dirty, its block address and contents are pushed into a two-entry first-in, first-out eviction queue, and the fill starts immediately. The queue empties into memory through a separate valid/ready write port in the background. A miss whose line is still waiting in that queue takes its data from the queue and does not read memory. If a dirty line must be displaced while the queue is full, the request waits until the queue accepts it.

The default geometry is a 5-bit byte address, two lines of two bytes each, and least-recently-used replacement among valid lines.

Top module: `wbc_cache`

## Requirements
- R1: After reset every line is invalid, `cpu_req_ready` is 1, and `cpu_rsp_valid`, `mem_rd_req` and `mem_wr_valid` are 0, so the first access of any address is a miss.
- R2: A load to a resident line returns the addressed byte with `cpu_rsp_hit`=1 and causes no memory read. Each accepted request produces exactly one response pulse, one cycle wide.
- R3: A store to a resident line updates only the cached byte and marks the line dirty. It causes no memory write, and a later load of that address returns the stored byte.
- R4: On a miss the cache holds `mem_rd_req` high with `mem_rd_blk` = address bits [4:1] stable until `mem_rd_ack`. The returned line has byte offset 0 in bits [7:0] and offset 1 in bits [15:8]. The line is installed valid and clean, and the store byte is then applied. The response has `cpu_rsp_hit`=0.
- R5: The replacement choice is the lowest-numbered invalid line if one exists, and otherwise the least recently used line. Both hits and fills count as uses.
- R6: Replacing a clean line produces no memory write.
- R7: Replacing a dirty line enqueues its entire line with its block address. Queue entries leave in the order they entered, one per `mem_wr_valid`/`mem_wr_ready` handshake, and each entry's block address and data stay stable while `mem_wr_ready` is low.
- R8: A miss whose block address matches an entry still in the eviction queue takes the line from the newest matching entry and issues no memory read.
- R9: When a dirty line must be replaced and the queue already holds two entries, the request gives no response and issues no memory read until an entry drains.
- R10: After the dirty data has been displaced by loads of untouched blocks and the queue has drained, memory holds the same bytes as a flat reference memory that applied every store.
- R11: The hit/miss classification of every response matches a reference model with the same geometry and replacement rule.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_req_valid | input | 1 | Processor request present |
| cpu_req_ready | output | 1 | Cache can accept a request this cycle |
| cpu_req_write | input | 1 | 1 = store, 0 = load |
| cpu_req_addr | input | 5 | Byte address |
| cpu_req_wdata | input | 8 | Store byte |
| cpu_rsp_valid | output | 1 | One-cycle response pulse |
| cpu_rsp_hit | output | 1 | Request was served from a resident line |
| cpu_rsp_rdata | output | 8 | Loaded byte (store byte for stores) |
| mem_rd_req | output | 1 | Line read requested |
| mem_rd_blk | output | 4 | Block address of the line to read |
| mem_rd_ack | input | 1 | Read data valid this cycle |
| mem_rd_line | input | 16 | Line read from memory |
| mem_wr_valid | output | 1 | Eviction queue head is presented |
| mem_wr_ready | input | 1 | Memory accepts the presented line |
| mem_wr_blk | output | 4 | Block address of the line being written |
| mem_wr_line | output | 16 | Line being written |

## Verification
A dirty bit that is lost or never set shows nothing at the ports when it goes wrong. The error appears only when that line is displaced. At that point either no write-back appears, or a stale value comes back on the next miss to that block. The bench therefore ends each phase by forcing every line out and comparing the whole memory. A wrong replacement age shows up one access later as a flipped hit flag. A queue that forwards stale or no data shows up as a wrong loaded byte, or as an extra memory read, on the very miss that should have been forwarded.

// File: rtl/wbc_pkg.sv
package wbc_pkg;
    localparam int ADDR_W      = 5;
    localparam int OFFS_W      = 1;
    localparam int BYTE_W      = 8;
    localparam int CACHE_LINES = 2;
    localparam int WBUF_DEPTH  = 2;

    localparam int LINE_BYTES = 1 << OFFS_W;
    localparam int LINE_W     = LINE_BYTES * BYTE_W;
    localparam int BLK_W      = ADDR_W - OFFS_W;
    localparam int WAY_W      = (CACHE_LINES > 1) ? $clog2(CACHE_LINES) : 1;

    typedef logic [BLK_W-1:0]  blk_t;
    typedef logic [LINE_W-1:0] line_t;
    typedef logic [BYTE_W-1:0] byte_t;
    typedef logic [OFFS_W-1:0] offs_t;
    typedef logic [WAY_W-1:0]  way_t;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_LOOKUP = 2'd1,
        ST_FILL   = 2'd2
    } cstate_e;

    function automatic byte_t get_byte(input line_t ln, input offs_t off);
        byte_t r;
        r = '0;
        for (int i = 0; i < LINE_BYTES; i++) begin
            if (offs_t'(i) == off) r = ln[i*BYTE_W +: BYTE_W];
        end
        return r;
    endfunction

    function automatic line_t put_byte(input line_t ln, input offs_t off, input byte_t b);
        line_t r;
        r = ln;
        for (int i = 0; i < LINE_BYTES; i++) begin
            if (offs_t'(i) == off) r[i*BYTE_W +: BYTE_W] = b;
        end
        return r;
    endfunction
endpackage

// File: rtl/wbc_lru.sv
module wbc_lru #(
    parameter int WAYS = wbc_pkg::CACHE_LINES,
    parameter int IW   = wbc_pkg::WAY_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          touch_en,
    input  logic [IW-1:0] touch_way,
    output logic [IW-1:0] oldest_way
);
    // Rank 0 is the most recent use, rank WAYS-1 the least recent.
    logic [WAYS-1:0][IW-1:0] age_d, age_q;
    logic [WAYS-1:0]         is_old;

    always_comb begin
        age_d = age_q;
        if (touch_en) begin
            for (int i = 0; i < WAYS; i++) begin
                if (IW'(i) == touch_way) begin
                    age_d[i] = '0;
                end else if (age_q[i] < age_q[touch_way]) begin
                    age_d[i] = age_q[i] + 1'b1;
                end
            end
        end
    end

    always_comb begin
        oldest_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            is_old[i] = (age_q[i] == IW'(WAYS - 1));
            if (is_old[i]) oldest_way = IW'(i);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < WAYS; i++) age_q[i] <= IW'(i);
        end else begin
            age_q <= age_d;
        end
    end

    AST_LRU_SINGLE_OLDEST: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(is_old) == 1); // R5
endmodule

// File: rtl/wbc_evict_fifo.sv
module wbc_evict_fifo #(
    parameter int DEPTH  = wbc_pkg::WBUF_DEPTH,
    parameter int BLK_W  = wbc_pkg::BLK_W,
    parameter int LINE_W = wbc_pkg::LINE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_en,
    input  logic [BLK_W-1:0]  push_blk,
    input  logic [LINE_W-1:0] push_line,
    output logic              full,
    output logic              wr_valid,
    input  logic              wr_ready,
    output logic [BLK_W-1:0]  wr_blk,
    output logic [LINE_W-1:0] wr_line,
    input  logic [BLK_W-1:0]  probe_blk,
    output logic              probe_hit,
    output logic [LINE_W-1:0] probe_line
);
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    typedef struct packed {
        logic [DEPTH-1:0][BLK_W-1:0]  blk;
        logic [DEPTH-1:0][LINE_W-1:0] line;
        logic [PW-1:0]                head;
        logic [PW-1:0]                tail;
        logic [PW:0]                  cnt;
    } fifo_s;

    fifo_s f_d, f_q;
    logic  pop;

    function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
        return (p == PW'(DEPTH - 1)) ? '0 : p + 1'b1;
    endfunction

    assign wr_valid = (f_q.cnt != '0);
    assign wr_blk   = f_q.blk[f_q.head];
    assign wr_line  = f_q.line[f_q.head];
    assign full     = (f_q.cnt == (PW+1)'(DEPTH));

    always_comb begin
        f_d = f_q;
        pop = wr_valid && wr_ready;
        if (pop) f_d.head = nxt(f_q.head);
        if (push_en) begin
            f_d.blk[f_q.tail]  = push_blk;
            f_d.line[f_q.tail] = push_line;
            f_d.tail           = nxt(f_q.tail);
        end
        case ({push_en, pop})
            2'b10:   f_d.cnt = f_q.cnt + 1'b1;
            2'b01:   f_d.cnt = f_q.cnt - 1'b1;
            default: f_d.cnt = f_q.cnt;
        endcase
    end

    // Walk oldest to newest so the newest matching copy wins.
    always_comb begin
        logic [PW-1:0] p;
        p          = f_q.head;
        probe_hit  = 1'b0;
        probe_line = '0;
        for (int k = 0; k < DEPTH; k++) begin
            if (((PW+1)'(k) < f_q.cnt) && (f_q.blk[p] == probe_blk)) begin
                probe_hit  = 1'b1;
                probe_line = f_q.line[p];
            end
            p = nxt(p);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) f_q <= '0;
        else        f_q <= f_d;
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push_en |-> !full); // R9
    AST_WR_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_blk) && $stable(wr_line))); // R7
endmodule

// File: rtl/wbc_cache.sv
module wbc_cache
    import wbc_pkg::*;
(
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         cpu_req_valid,
    output logic                         cpu_req_ready,
    input  logic                         cpu_req_write,
    input  logic [wbc_pkg::ADDR_W-1:0]   cpu_req_addr,
    input  logic [wbc_pkg::BYTE_W-1:0]   cpu_req_wdata,
    output logic                         cpu_rsp_valid,
    output logic                         cpu_rsp_hit,
    output logic [wbc_pkg::BYTE_W-1:0]   cpu_rsp_rdata,
    output logic                         mem_rd_req,
    output logic [wbc_pkg::BLK_W-1:0]    mem_rd_blk,
    input  logic                         mem_rd_ack,
    input  logic [wbc_pkg::LINE_W-1:0]   mem_rd_line,
    output logic                         mem_wr_valid,
    input  logic                         mem_wr_ready,
    output logic [wbc_pkg::BLK_W-1:0]    mem_wr_blk,
    output logic [wbc_pkg::LINE_W-1:0]   mem_wr_line
);
    typedef struct packed {
        cstate_e                       st;
        logic                          op_we;
        logic [ADDR_W-1:0]             op_addr;
        byte_t                         op_wdata;
        way_t                          victim;
        logic                          rsp_valid;
        logic                          rsp_hit;
        byte_t                         rsp_data;
        logic [CACHE_LINES-1:0]        vld;
        logic [CACHE_LINES-1:0]        drt;
        logic [CACHE_LINES-1:0][BLK_W-1:0]  tag;
        logic [CACHE_LINES-1:0][LINE_W-1:0] line;
    } cache_s;

    cache_s s_d, s_q;

    blk_t  op_blk;
    offs_t op_off;
    logic  hit_any, have_free;
    way_t  hit_way, free_way, vict, lru_way;
    logic  touch_en;
    way_t  touch_way;
    logic  push_en;
    blk_t  push_blk;
    line_t push_line;
    logic  wb_full, probe_hit;
    line_t probe_line;

    assign op_blk = s_q.op_addr[ADDR_W-1:OFFS_W];
    assign op_off = s_q.op_addr[OFFS_W-1:0];

    wbc_lru #(.WAYS(CACHE_LINES), .IW(WAY_W)) u_lru (
        .clk        (clk),
        .rst_n      (rst_n),
        .touch_en   (touch_en),
        .touch_way  (touch_way),
        .oldest_way (lru_way)
    );

    wbc_evict_fifo #(.DEPTH(WBUF_DEPTH), .BLK_W(BLK_W), .LINE_W(LINE_W)) u_evq (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_en    (push_en),
        .push_blk   (push_blk),
        .push_line  (push_line),
        .full       (wb_full),
        .wr_valid   (mem_wr_valid),
        .wr_ready   (mem_wr_ready),
        .wr_blk     (mem_wr_blk),
        .wr_line    (mem_wr_line),
        .probe_blk  (op_blk),
        .probe_hit  (probe_hit),
        .probe_line (probe_line)
    );

    // Tag match and replacement choice.
    always_comb begin
        hit_any   = 1'b0;
        hit_way   = '0;
        have_free = 1'b0;
        free_way  = '0;
        for (int i = 0; i < CACHE_LINES; i++) begin
            if (s_q.vld[i] && (s_q.tag[i] == op_blk)) begin
                hit_any = 1'b1;
                hit_way = way_t'(i);
            end
        end
        for (int i = CACHE_LINES - 1; i >= 0; i--) begin
            if (!s_q.vld[i]) begin
                have_free = 1'b1;
                free_way  = way_t'(i);
            end
        end
        vict = have_free ? free_way : lru_way;
    end

    always_comb begin
        logic  fill_en;
        way_t  fill_way;
        line_t fill_src;
        line_t cur;

        s_d        = s_q;
        s_d.rsp_valid = 1'b0;
        touch_en   = 1'b0;
        touch_way  = '0;
        push_en    = 1'b0;
        push_blk   = '0;
        push_line  = '0;
        mem_rd_req = 1'b0;
        fill_en    = 1'b0;
        fill_way   = '0;
        fill_src   = '0;
        cur        = '0;

        case (s_q.st)
            ST_IDLE: begin
                if (cpu_req_valid) begin
                    s_d.st       = ST_LOOKUP;
                    s_d.op_we    = cpu_req_write;
                    s_d.op_addr  = cpu_req_addr;
                    s_d.op_wdata = cpu_req_wdata;
                end
            end
            ST_LOOKUP: begin
                if (hit_any) begin
                    cur           = s_q.line[hit_way];
                    s_d.rsp_valid = 1'b1;
                    s_d.rsp_hit   = 1'b1;
                    if (s_q.op_we) begin
                        s_d.line[hit_way] = put_byte(cur, op_off, s_q.op_wdata);
                        s_d.drt[hit_way]  = 1'b1;
                        s_d.rsp_data      = s_q.op_wdata;
                    end else begin
                        s_d.rsp_data      = get_byte(cur, op_off);
                    end
                    touch_en  = 1'b1;
                    touch_way = hit_way;
                    s_d.st    = ST_IDLE;
                end else if (!(s_q.vld[vict] && s_q.drt[vict] && wb_full)) begin
                    if (s_q.vld[vict] && s_q.drt[vict]) begin
                        push_en   = 1'b1;
                        push_blk  = s_q.tag[vict];
                        push_line = s_q.line[vict];
                    end
                    s_d.vld[vict] = 1'b0;
                    s_d.drt[vict] = 1'b0;
                    s_d.victim    = vict;
                    if (probe_hit) begin
                        fill_en  = 1'b1;
                        fill_way = vict;
                        fill_src = probe_line;
                    end else begin
                        s_d.st = ST_FILL;
                    end
                end
            end
            ST_FILL: begin
                mem_rd_req = 1'b1;
                if (mem_rd_ack) begin
                    fill_en  = 1'b1;
                    fill_way = s_q.victim;
                    fill_src = mem_rd_line;
                end
            end
            default: s_d.st = ST_IDLE;
        endcase

        if (fill_en) begin
            s_d.vld[fill_way] = 1'b1;
            s_d.tag[fill_way] = op_blk;
            s_d.drt[fill_way] = s_q.op_we;
            s_d.line[fill_way] = s_q.op_we ? put_byte(fill_src, op_off, s_q.op_wdata) : fill_src;
            s_d.rsp_valid = 1'b1;
            s_d.rsp_hit   = 1'b0;
            s_d.rsp_data  = s_q.op_we ? s_q.op_wdata : get_byte(fill_src, op_off);
            touch_en  = 1'b1;
            touch_way = fill_way;
            s_d.st    = ST_IDLE;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign cpu_req_ready = (s_q.st == ST_IDLE);
    assign cpu_rsp_valid = s_q.rsp_valid;
    assign cpu_rsp_hit   = s_q.rsp_hit;
    assign cpu_rsp_rdata = s_q.rsp_data;
    assign mem_rd_blk    = op_blk;

    AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_rd_req && !mem_rd_ack) |=> (mem_rd_req && $stable(mem_rd_blk))); // R4
    AST_RSP_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |=> !cpu_rsp_valid); // R2
    AST_RSP_IN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_rsp_valid |-> (cpu_req_ready && !mem_rd_req)); // R2
endmodule

// File: tb/sim_wbc_cache.sv
`timescale 1ns/1ps
module sim_wbc_cache;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cpu_req_valid, cpu_req_ready, cpu_req_write;
    logic [4:0]  cpu_req_addr;
    logic [7:0]  cpu_req_wdata;
    logic        cpu_rsp_valid, cpu_rsp_hit;
    logic [7:0]  cpu_rsp_rdata;
    logic        mem_rd_req, mem_rd_ack;
    logic [3:0]  mem_rd_blk;
    logic [15:0] mem_rd_line;
    logic        mem_wr_valid, mem_wr_ready;
    logic [3:0]  mem_wr_blk;
    logic [15:0] mem_wr_line;

    always #10 clk = ~clk;

    wbc_cache u0 (
        .clk(clk), .rst_n(rst_n),
        .cpu_req_valid(cpu_req_valid), .cpu_req_ready(cpu_req_ready),
        .cpu_req_write(cpu_req_write), .cpu_req_addr(cpu_req_addr),
        .cpu_req_wdata(cpu_req_wdata),
        .cpu_rsp_valid(cpu_rsp_valid), .cpu_rsp_hit(cpu_rsp_hit),
        .cpu_rsp_rdata(cpu_rsp_rdata),
        .mem_rd_req(mem_rd_req), .mem_rd_blk(mem_rd_blk),
        .mem_rd_ack(mem_rd_ack), .mem_rd_line(mem_rd_line),
        .mem_wr_valid(mem_wr_valid), .mem_wr_ready(mem_wr_ready),
        .mem_wr_blk(mem_wr_blk), .mem_wr_line(mem_wr_line)
    );

    int checks = 0, fails = 0;
    logic [7:0] mem  [0:31];
    logic [7:0] refm [0:31];
    logic [3:0] wlog [0:63];
    int rd_wait, rd_count, wr_count;

    function automatic logic [7:0] init_byte(input int a);
        case (a)
            0: return 8'd78;   1: return 8'd29;   2: return 8'd120;  3: return 8'd123;
            4: return 8'd71;   5: return 8'd150;  6: return 8'd162;  7: return 8'd173;
            8: return 8'd18;   9: return 8'd21;   10: return 8'd33;  11: return 8'd28;
            12: return 8'd19;  13: return 8'd200; 14: return 8'd210; 15: return 8'd225;
            default: return 8'((a * 37 + 11) % 256);
        endcase
    endfunction

    // Memory model: line reads after two wait cycles, line writes on handshake.
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 32; i++) mem[i] <= init_byte(i);
            mem_rd_ack <= 1'b0; mem_rd_line <= '0;
            rd_wait <= 0; rd_count <= 0; wr_count <= 0;
        end else begin
            if (mem_rd_ack) mem_rd_ack <= 1'b0;
            else if (mem_rd_req) begin
                if (rd_wait == 2) begin
                    mem_rd_ack  <= 1'b1;
                    mem_rd_line <= {mem[{mem_rd_blk, 1'b1}], mem[{mem_rd_blk, 1'b0}]};
                    rd_wait     <= 0;
                    rd_count    <= rd_count + 1;
                end else rd_wait <= rd_wait + 1;
            end else rd_wait <= 0;
            if (mem_wr_valid && mem_wr_ready) begin
                mem[{mem_wr_blk, 1'b0}] <= mem_wr_line[7:0];
                mem[{mem_wr_blk, 1'b1}] <= mem_wr_line[15:8];
                wlog[wr_count[5:0]]     <= mem_wr_blk;
                wr_count                <= wr_count + 1;
            end
        end
    end

    // Reference model: flat memory plus two-line LRU tag tracking.
    bit m_vld [0:1];
    int m_tag [0:1];
    int m_mru;
    int m_hits = 0, m_miss = 0, s_hits = 0, s_miss = 0;
    bit last_hit;
    logic [7:0] last_data;

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic model_step(input bit we, input int addr, input int wd, output bit eh, output int ed);
        int blk, w;
        blk = addr >> 1; eh = 0; w = 0;
        for (int i = 0; i < 2; i++) if (m_vld[i] && m_tag[i] == blk) begin eh = 1; w = i; end
        if (!eh) begin
            if (!m_vld[0]) w = 0; else if (!m_vld[1]) w = 1; else w = 1 - m_mru;
            m_vld[w] = 1; m_tag[w] = blk;
        end
        m_mru = w;
        if (eh) m_hits++; else m_miss++;
        ed = int'(refm[addr]);
        if (we) refm[addr] = 8'(wd);
    endtask

    task automatic issue(input bit we, input int addr, input int wd);
        @(negedge clk);
        cpu_req_valid = 1'b1; cpu_req_write = we;
        cpu_req_addr = 5'(addr); cpu_req_wdata = 8'(wd);
        while (!cpu_req_ready) @(negedge clk);
        @(negedge clk);
        cpu_req_valid = 1'b0;
    endtask

    task automatic finish_op(input bit we, input bit eh, input int ed, input string req);
        int t;
        t = 0;
        while (!cpu_rsp_valid && t < 200) begin @(negedge clk); t++; end
        check(cpu_rsp_valid, req, "response timeout", 0, 1);
        last_hit = cpu_rsp_hit; last_data = cpu_rsp_rdata;
        if (cpu_rsp_hit) s_hits++; else s_miss++;
        check(cpu_rsp_hit == eh, req, "hit flag", int'(cpu_rsp_hit), int'(eh));
        if (!we) check(cpu_rsp_rdata == 8'(ed), req, "load data", int'(cpu_rsp_rdata), ed);
    endtask

    task automatic do_op(input bit we, input int addr, input int wd, input string req);
        bit eh; int ed;
        model_step(we, addr, wd, eh, ed);
        issue(we, addr, wd);
        finish_op(we, eh, ed, req);
    endtask

    task automatic flush_lines();
        do_op(0, 24, 0, "R10");
        do_op(0, 26, 0, "R10");
        repeat (20) @(negedge clk);
    endtask

    // Stimulus table: {write, address, store byte}.
    localparam int NTR = 18;
    localparam logic [13:0] TRACE [0:NTR-1] = '{
        {1'b0, 5'd1,  8'h00}, {1'b0, 5'd7,  8'h00}, {1'b1, 5'd0,  8'h11},
        {1'b1, 5'd5,  8'h22}, {1'b0, 5'd10, 8'h00}, {1'b1, 5'd5,  8'h33},
        {1'b1, 5'd10, 8'h44}, {1'b0, 5'd0,  8'h00}, {1'b0, 5'd1,  8'h00},
        {1'b0, 5'd20, 8'h00}, {1'b1, 5'd21, 8'h55}, {1'b0, 5'd7,  8'h00},
        {1'b0, 5'd5,  8'h00}, {1'b0, 5'd11, 8'h00}, {1'b0, 5'd20, 8'h00},
        {1'b1, 5'd31, 8'h66}, {1'b0, 5'd0,  8'h00}, {1'b0, 5'd30, 8'h00}
    };

    task automatic summary();
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        summary();
        $finish;
    end

    initial begin
        int w0, r0, wb, t;
        bit eh; int ed;
        for (int i = 0; i < 32; i++) refm[i] = init_byte(i);
        m_vld[0] = 0; m_vld[1] = 0; m_tag[0] = 0; m_tag[1] = 0; m_mru = 0;
        rst_n = 1'b0; cpu_req_valid = 1'b0; cpu_req_write = 1'b0;
        cpu_req_addr = '0; cpu_req_wdata = '0; mem_wr_ready = 1'b1;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: idle outputs after reset
        check(cpu_req_ready == 1'b1, "R1", "req ready", int'(cpu_req_ready), 1);
        check(!cpu_rsp_valid && !mem_rd_req && !mem_wr_valid, "R1", "idle strobes",
              int'({cpu_rsp_valid, mem_rd_req, mem_wr_valid}), 0);

        // Table walk: first access misses (R1), hits/fills (R2 R4), model match (R11)
        for (int i = 0; i < NTR; i++)
            do_op(TRACE[i][13], int'(TRACE[i][12:8]), int'(TRACE[i][7:0]), "R2 R4 R11");

        // R6: clean replacement writes nothing
        flush_lines();
        w0 = wr_count;
        do_op(0, 28, 0, "R6");
        repeat (6) @(negedge clk);
        check(wr_count == w0, "R6", "writes after clean eviction", wr_count, w0);

        // R3: store hit stays in cache
        do_op(1, 28, 8'h5A, "R3");
        repeat (6) @(negedge clk);
        check(wr_count == w0 && !mem_wr_valid, "R3", "writes after store hit", wr_count, w0);
        do_op(0, 28, 0, "R3");
        check(last_data == 8'h5A, "R3", "reload stored byte", int'(last_data), 8'h5A);

        // R5: least recently used line is replaced
        do_op(0, 26, 0, "R5");
        check(last_hit == 1'b1, "R5", "hit on older resident line", int'(last_hit), 1);
        do_op(0, 0, 0, "R5");
        do_op(0, 28, 0, "R5");
        check(last_hit == 1'b0, "R5", "LRU line was evicted", int'(last_hit), 0);

        // R8/R9/R7: queue forwarding, full-queue stall, drain order
        flush_lines();
        @(negedge clk); mem_wr_ready = 1'b0;
        wb = wr_count;
        do_op(1, 0, 8'hA1, "R8");
        do_op(1, 2, 8'hB2, "R8");
        do_op(0, 4, 0, "R8");
        r0 = rd_count;
        do_op(0, 0, 0, "R8");
        check(rd_count == r0, "R8", "memory reads on queued block", rd_count, r0);
        check(last_data == 8'hA1, "R8", "forwarded byte", int'(last_data), 8'hA1);
        do_op(1, 4, 8'hC3, "R9");
        do_op(1, 0, 8'hD4, "R9");
        model_step(0, 16, 0, eh, ed);
        issue(0, 16, 0);
        t = 0;
        for (int k = 0; k < 12; k++) begin
            if (cpu_rsp_valid || mem_rd_req) t++;
            @(negedge clk);
        end
        check(t == 0, "R9", "activity while queue full", t, 0);
        mem_wr_ready = 1'b1;
        finish_op(0, eh, ed, "R9");
        repeat (12) @(negedge clk);
        check(wr_count == wb + 3, "R7", "write-back count", wr_count, wb + 3);
        check(wlog[wb[5:0]] == 4'd0 && wlog[6'(wb + 1)] == 4'd1 && wlog[6'(wb + 2)] == 4'd2,
              "R7", "drain order", int'({wlog[wb[5:0]], wlog[6'(wb + 1)], wlog[6'(wb + 2)]}), 12'h012);

        // R10: memory matches reference after all dirty data is displaced
        flush_lines();
        for (int i = 0; i < 32; i++)
            check(mem[i] == refm[i], "R10", $sformatf("mem[%0d]", i), int'(mem[i]), int'(refm[i]));

        // R11: totals
        check(s_hits == m_hits, "R11", "hit count", s_hits, m_hits);
        check(s_miss == m_miss, "R11", "miss count", s_miss, m_miss);

        summary();
        $finish;
    end
endmodule